// File: doc/BRIEF.md
# Memory protection enable controller

This block is the control front end of a memory protection unit. It holds a three-bit control word (protection enable, handler enable and privileged background-map enable) and a region-select register, both reached over a simple single-cycle register bus. For every memory access it combines the control word with the access context and with the hit and permission result of an external region matcher. It then decides whether the access faults, whether it falls back to the default memory map, or whether the region result governs it.

The effective enable depends on the handler context. In hard-fault, non-maskable and fault-mask-escalated handlers, protection stays on only when both the enable bit and the handler-enable bit are set. The background map behaves as the lowest-priority region. Only privileged accesses may use it, and any matching region overrides it. Instruction fetches from the system address partition are always refused. The selected region index is passed to the region matcher, masked to the number of implemented regions.

Top module: `prot_enable_ctrl`

## Requirements
- R1: After reset the control word reads 0, `protActive` is 0 and `undefWarn` is 0.
- R2: The control register is at word address 0. It stores write data bits 2 (background map), 1 (handler enable) and 0 (enable), and reads them back at the same positions. All other bits read 0. Reads are combinational. A write to an unmapped address changes nothing, and unmapped addresses read 0.
- R3: With protection inactive, a valid access that is not a system-partition fetch gives `accUseDefault`=1 and `accFault`=0, for privileged and unprivileged accesses alike, whatever the background bit holds.
- R4: With protection active, a region hit overrides the background map: `accUseDefault`=0 and `accFault` = NOT `regionPermit`.
- R5: With protection active, a privileged access that misses every region and has the background bit set gives `accUseDefault`=1 and `accFault`=0.
- R6: With protection active, an unprivileged access that misses every region faults, whatever the background bit holds.
- R7: With protection active and the background bit clear, a privileged access that misses every region faults.
- R8: In an escalated handler context (`accEscalated`=1), protection is active only when both the enable bit and the handler-enable bit are 1. Outside that context it follows the enable bit alone.
- R9: Handler enable set with enable clear counts as protection inactive. A control write of that combination sets `undefWarn`, which stays 1 until reset.
- R10: The region-number register is at word address 1. It stores and reads back write data bits 7:0, and higher bits read 0. `regionSel` carries its low log2(NUM_REGIONS) bits (NUM_REGIONS a power of two). The register has no reset value.
- R11: A valid instruction fetch (`accFetch`=1) to the system partition (`accSysSpace`=1) always gives `accFault`=1 and `accUseDefault`=0, whatever the control word or region result holds.
- R12: The decision outputs are combinational in the access inputs. With `accValid`=0 both `accFault` and `accUseDefault` are 0, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (4) | Register word address |
| busWe | input | 1 | Register write enable |
| busWdata | input | DATA_W (32) | Register write data |
| busRdata | output | DATA_W (32) | Register read data, combinational from busAddr |
| accValid | input | 1 | An access is presented this cycle |
| accPriv | input | 1 | Access is privileged |
| accEscalated | input | 1 | Processor is in an escalated fault or non-maskable handler |
| accFetch | input | 1 | Access is an instruction fetch |
| accSysSpace | input | 1 | Address lies in the system partition |
| regionHit | input | 1 | External matcher found a matching region |
| regionPermit | input | 1 | Matching region permits the access |
| accFault | output | 1 | Access faults |
| accUseDefault | output | 1 | Access uses the default memory map |
| protActive | output | 1 | Protection checking applies in the current context |
| regionSel | output | IDX_W (3) | Selected region index for the matcher |
| undefWarn | output | 1 | Sticky flag for the undefined control combination |

## Verification
Register writes and the sticky warning take effect at the rising edge that samples `busWe`. Read data, `regionSel`, `protActive` and the fault and default-map outputs are combinational and are due in the same cycle as their inputs. The bench therefore drives every input just after a falling edge and samples 1 ns later, well before the next rising edge. For written state it samples only after the falling edge that follows the write edge. This gives zero-cycle checks for the decision path and one-edge checks for the registers, with no dependence on the order of processes at the active edge.

// File: rtl/prot_ctrl_pkg.sv
package prot_ctrl_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_HND_BIT = 1;
  localparam int CTRL_BG_BIT  = 2;
  localparam int CTRL_W       = 3;

  typedef struct packed {
    logic ctrlWr;
    logic rselWr;
    logic undefWr;
    logic rdCtrl;
    logic rdRsel;
  } regStrobes_t;
endpackage

// File: rtl/prot_bus_ctrl.sv
module prot_bus_ctrl
  import prot_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int RSEL_ADDR = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [1:0]        ctrlLowBits,
  output regStrobes_t       strobes
);
  logic hitCtrl;
  logic hitRsel;

  assign hitCtrl = (busAddr == ADDR_W'(CTRL_ADDR));
  assign hitRsel = (busAddr == ADDR_W'(RSEL_ADDR));

  always_comb begin
    strobes.rdCtrl  = hitCtrl;
    strobes.rdRsel  = hitRsel;
    strobes.ctrlWr  = busWe && hitCtrl;
    strobes.rselWr  = busWe && hitRsel;
    strobes.undefWr = busWe && hitCtrl && ctrlLowBits[CTRL_HND_BIT] && !ctrlLowBits[CTRL_EN_BIT];
  end
endmodule

// File: rtl/prot_reg_file.sv
module prot_reg_file
  import prot_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RNUM_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic [RNUM_W-1:0] rnumWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [IDX_W-1:0]  regionSel,
  output logic              undefWarn
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [RNUM_W-1:0] rnumQ;
  logic              warnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      warnQ <= 1'b0;
    end else begin
      if (strobes.ctrlWr)  ctrlQ <= ctrlWdata;
      if (strobes.undefWr) warnQ <= 1'b1;
    end
  end

  // Region number deliberately has no reset value.
  always_ff @(posedge clk) begin
    if (strobes.rselWr) rnumQ <= rnumWdata;
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdCtrl)      busRdata[CTRL_W-1:0] = ctrlQ;
    else if (strobes.rdRsel) busRdata[RNUM_W-1:0] = rnumQ;
  end

  assign ctrlBits  = ctrlQ;
  assign regionSel = rnumQ[IDX_W-1:0];
  assign undefWarn = warnQ;

  logic rnumUnused;
  generate
    if (RNUM_W > IDX_W) begin : g_rnumHi
      assign rnumUnused = ^rnumQ[RNUM_W-1:IDX_W];
    end else begin : g_rnumFull
      assign rnumUnused = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prot_access_judge.sv
module prot_access_judge
  import prot_ctrl_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrlBits,
  input  logic              accValid,
  input  logic              accPriv,
  input  logic              accEscalated,
  input  logic              accFetch,
  input  logic              accSysSpace,
  input  logic              regionHit,
  input  logic              regionPermit,
  output logic              protActive,
  output logic              accFault,
  output logic              accUseDefault
);
  logic ctrlEn, ctrlHnd, ctrlBg, active;

  assign ctrlEn  = ctrlBits[CTRL_EN_BIT];
  assign ctrlHnd = ctrlBits[CTRL_HND_BIT];
  assign ctrlBg  = ctrlBits[CTRL_BG_BIT];

  // Handler enable without enable falls out as inactive here.
  assign active     = ctrlEn && (!accEscalated || ctrlHnd);
  assign protActive = active;

  always_comb begin
    accFault      = 1'b0;
    accUseDefault = 1'b0;
    if (accValid) begin
      if (accFetch && accSysSpace) accFault = 1'b1;
      else if (!active)            accUseDefault = 1'b1;
      else if (regionHit)          accFault = !regionPermit;
      else if (accPriv && ctrlBg)  accUseDefault = 1'b1;
      else                         accFault = 1'b1;
    end
  end
endmodule

// File: rtl/prot_enable_ctrl.sv
module prot_enable_ctrl
  import prot_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int RNUM_W      = 8,
  parameter int NUM_REGIONS = 8,
  parameter int CTRL_ADDR   = 0,
  parameter int RSEL_ADDR   = 1,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              accValid,
  input  logic              accPriv,
  input  logic              accEscalated,
  input  logic              accFetch,
  input  logic              accSysSpace,
  input  logic              regionHit,
  input  logic              regionPermit,
  output logic              accFault,
  output logic              accUseDefault,
  output logic              protActive,
  output logic [IDX_W-1:0]  regionSel,
  output logic              undefWarn
);
  regStrobes_t       strobes;
  logic [CTRL_W-1:0] ctrlBits;
  logic              wdataUnused;

  assign wdataUnused = ^busWdata[DATA_W-1:RNUM_W];

  prot_bus_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RSEL_ADDR(RSEL_ADDR)) busCtrl_i (
    .busAddr     (busAddr),
    .busWe       (busWe),
    .ctrlLowBits (busWdata[1:0]),
    .strobes     (strobes)
  );

  prot_reg_file #(.DATA_W(DATA_W), .RNUM_W(RNUM_W), .IDX_W(IDX_W)) regFile_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ctrlWdata (busWdata[CTRL_W-1:0]),
    .rnumWdata (busWdata[RNUM_W-1:0]),
    .busRdata  (busRdata),
    .ctrlBits  (ctrlBits),
    .regionSel (regionSel),
    .undefWarn (undefWarn)
  );

  prot_access_judge judge_i (
    .ctrlBits      (ctrlBits),
    .accValid      (accValid),
    .accPriv       (accPriv),
    .accEscalated  (accEscalated),
    .accFetch      (accFetch),
    .accSysSpace   (accSysSpace),
    .regionHit     (regionHit),
    .regionPermit  (regionPermit),
    .protActive    (protActive),
    .accFault      (accFault),
    .accUseDefault (accUseDefault)
  );
endmodule

// File: rtl/prot_enable_ctrl_chk.sv
module prot_enable_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] ctrlBits,
  input logic       accValid,
  input logic       accPriv,
  input logic       accEscalated,
  input logic       accFetch,
  input logic       accSysSpace,
  input logic       regionHit,
  input logic       regionPermit,
  input logic       accFault,
  input logic       accUseDefault,
  input logic       protActive,
  input logic       undefWarn
);
  logic sysXn;
  assign sysXn = accValid && accFetch && accSysSpace;

  p_disabled_default_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !protActive && !sysXn) |-> (accUseDefault && !accFault));

  p_hit_override_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && protActive && regionHit && !sysXn) |-> (!accUseDefault && (accFault == !regionPermit)));

  p_unpriv_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && protActive && !regionHit && !accPriv) |-> accFault);

  p_active_needs_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    protActive |-> ctrlBits[0]);

  p_esc_needs_hnd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accEscalated && protActive) |-> ctrlBits[1]);

  p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    undefWarn |=> undefWarn);

  p_sys_fetch_fault_r11: assert property (@(posedge clk) disable iff (!rstN)
    sysXn |-> (accFault && !accUseDefault));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accFault && !accUseDefault));

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accFault, accUseDefault}));
endmodule

bind prot_enable_ctrl prot_enable_ctrl_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .ctrlBits      (ctrlBits),
  .accValid      (accValid),
  .accPriv       (accPriv),
  .accEscalated  (accEscalated),
  .accFetch      (accFetch),
  .accSysSpace   (accSysSpace),
  .regionHit     (regionHit),
  .regionPermit  (regionPermit),
  .accFault      (accFault),
  .accUseDefault (accUseDefault),
  .protActive    (protActive),
  .undefWarn     (undefWarn)
);

// File: tb/prot_enable_ctrl_tb_top.sv
`timescale 1ns/1ps
module prot_enable_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic accValid = 0, accPriv = 0, accEscalated = 0, accFetch = 0, accSysSpace = 0;
  logic regionHit = 0, regionPermit = 0;
  logic accFault, accUseDefault, protActive, undefWarn;
  logic [2:0] regionSel;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prot_enable_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .accValid(accValid), .accPriv(accPriv), .accEscalated(accEscalated),
    .accFetch(accFetch), .accSysSpace(accSysSpace), .regionHit(regionHit),
    .regionPermit(regionPermit), .accFault(accFault), .accUseDefault(accUseDefault),
    .protActive(protActive), .regionSel(regionSel), .undefWarn(undefWarn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  // Drive an access after a falling edge, sample 1 ns later.
  task automatic access(input logic v, p, e, f, s, h, pm);
    @(negedge clk);
    accValid = v; accPriv = p; accEscalated = e; accFetch = f;
    accSysSpace = s; regionHit = h; regionPermit = pm;
    #1;
  endtask

  task automatic expectAcc(input string req, input logic expFault, input logic expDef);
    check({req, " fault"}, {31'b0, accFault}, {31'b0, expFault});
    check({req, " default"}, {31'b0, accUseDefault}, {31'b0, expDef});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    readReg(4'd0, d);
    check("R1 ctrl", d, 32'h0);
    check("R1 warn", {31'b0, undefWarn}, 32'h0);
    access(1, 1, 0, 0, 0, 0, 0);
    check("R1 active", {31'b0, protActive}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    writeReg(4'd0, 32'hFFFF_FFFF);
    readReg(4'd0, d);
    check("R2 reserved zero", d, 32'h7);
    writeReg(4'd0, 32'h0000_0005);
    readReg(4'd0, d);
    check("R2 readback", d, 32'h5);
    writeReg(4'd5, 32'hFFFF_FFFF);
    readReg(4'd5, d);
    check("R2 unmapped read", d, 32'h0);
    readReg(4'd0, d);
    check("R2 unmapped write", d, 32'h5);
  endtask

  task automatic t_disabled;
    writeReg(4'd0, 32'h4);
    access(1, 1, 0, 0, 0, 0, 0); expectAcc("R3 priv", 0, 1);
    access(1, 0, 0, 0, 0, 0, 0); expectAcc("R3 unpriv", 0, 1);
    access(1, 0, 0, 0, 0, 1, 0); expectAcc("R3 hit deny ignored", 0, 1);
    check("R3 active", {31'b0, protActive}, 32'h0);
  endtask

  task automatic t_hit;
    writeReg(4'd0, 32'h5);
    access(1, 1, 0, 0, 0, 1, 1); expectAcc("R4 hit permit", 0, 0);
    access(1, 1, 0, 0, 0, 1, 0); expectAcc("R4 hit deny over bg", 1, 0);
    access(1, 0, 0, 1, 0, 1, 1); expectAcc("R4 unpriv fetch hit", 0, 0);
  endtask

  task automatic t_bg;
    writeReg(4'd0, 32'h5);
    access(1, 1, 0, 0, 0, 0, 0); expectAcc("R5 priv data bg", 0, 1);
    access(1, 1, 0, 1, 0, 0, 0); expectAcc("R5 priv fetch bg", 0, 1);
  endtask

  task automatic t_unpriv;
    writeReg(4'd0, 32'h5);
    access(1, 0, 0, 0, 0, 0, 0); expectAcc("R6 unpriv bg set", 1, 0);
    writeReg(4'd0, 32'h1);
    access(1, 0, 0, 0, 0, 0, 0); expectAcc("R6 unpriv bg clear", 1, 0);
  endtask

  task automatic t_nobg;
    writeReg(4'd0, 32'h1);
    access(1, 1, 0, 0, 0, 0, 0); expectAcc("R7 priv miss", 1, 0);
    check("R7 active", {31'b0, protActive}, 32'h1);
  endtask

  task automatic t_escalated;
    writeReg(4'd0, 32'h1);
    access(1, 0, 1, 0, 0, 0, 0); expectAcc("R8 esc hnd off", 0, 1);
    check("R8 esc inactive", {31'b0, protActive}, 32'h0);
    access(1, 0, 0, 0, 0, 0, 0);
    check("R8 normal active", {31'b0, protActive}, 32'h1);
    writeReg(4'd0, 32'h3);
    access(1, 0, 1, 0, 0, 0, 0); expectAcc("R8 esc hnd on", 1, 0);
    check("R8 esc active", {31'b0, protActive}, 32'h1);
  endtask

  task automatic t_undef;
    check("R9 warn before", {31'b0, undefWarn}, 32'h0);
    writeReg(4'd0, 32'h2);
    check("R9 warn set", {31'b0, undefWarn}, 32'h1);
    access(1, 0, 1, 0, 0, 0, 0); expectAcc("R9 esc inactive", 0, 1);
    access(1, 0, 0, 0, 0, 0, 0); expectAcc("R9 normal inactive", 0, 1);
    writeReg(4'd0, 32'h0);
    check("R9 warn sticky", {31'b0, undefWarn}, 32'h1);
  endtask

  task automatic t_regionsel;
    logic [31:0] d;
    writeReg(4'd1, 32'hABCD_12F5);
    readReg(4'd1, d);
    check("R10 readback", d, 32'hF5);
    check("R10 sel mask", {29'b0, regionSel}, 32'h5);
    writeReg(4'd1, 32'h0000_000B);
    #1 check("R10 sel mask 2", {29'b0, regionSel}, 32'h3);
  endtask

  task automatic t_xn;
    writeReg(4'd0, 32'h0);
    access(1, 1, 0, 1, 1, 0, 0); expectAcc("R11 disabled", 1, 0);
    writeReg(4'd0, 32'h5);
    access(1, 1, 0, 1, 1, 1, 1); expectAcc("R11 hit permit", 1, 0);
    access(1, 1, 0, 0, 1, 0, 0); expectAcc("R11 data ok", 0, 1);
  endtask

  task automatic t_idle;
    writeReg(4'd0, 32'h1);
    access(0, 0, 0, 0, 0, 0, 0); expectAcc("R12 idle", 0, 0);
    access(1, 0, 0, 0, 0, 0, 0); expectAcc("R12 same cycle", 1, 0);
    access(0, 0, 0, 0, 0, 0, 0); expectAcc("R12 idle again", 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_hit();
    t_bg();
    t_unpriv();
    t_nobg();
    t_escalated();
    t_undef();
    t_regionsel();
    t_xn();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule